// File: doc/BRIEF.md
# Programmable Scanline Interrupt Counter

This block is the interrupt timer of a cartridge bank controller. An eight-bit main counter is driven by a prescaler. The prescaler advances on ticks from one of four pre-qualified sources: CPU cycles, PPU A12 line events, PPU read strobes or CPU write strobes. Software programs the block through an eight-entry register port. The port holds the enable, a mode byte, a prescaler load, a counter load and an XOR key. Every value loaded into the prescaler or the counter is first XORed with the key.

The main counter steps once each time the masked prescaler wraps. It can count up or down, or it can be frozen. The wrap point comes from a mask that is either three or eight bits wide. Counting up ends at 0x00. Counting down ends at 0xFF. If the counter reaches its terminal value while the enable is set, the interrupt line goes high. It stays high until software acknowledges it.

A single A12 line event is expanded into a burst of eight ticks. This is done by the state machine `BURST_IDLE`/`BURST_RUN`: the event takes `BURST_IDLE -> BURST_RUN`, and the burst ends with `BURST_RUN -> BURST_IDLE` after the eighth tick. The interrupt line is driven by a second state machine. A terminal hit with the enable set takes `IRQ_QUIET -> IRQ_RAISED`, and an acknowledge takes `IRQ_RAISED -> IRQ_QUIET`.

Top module: `irq_line_counter`

## Requirements
- R1: After reset the interrupt is low and all stored state is zero: mode, enable, key, prescaler and counter. In this state the block is stopped and selects the CPU-cycle source.
- R2: A write to offset 0 copies data bit 0 into the enable. When that bit is 0, the write also drops a pending interrupt.
- R3: A write to offset 2 clears both the enable and any pending interrupt. A write to offset 3 sets the enable and leaves the interrupt line unchanged.
- R4: Offset 6 stores the key. A write to offset 4 loads the prescaler with data XOR key. A write to offset 5 loads the counter with data XOR key.
- R5: Mode bits 1:0 select the tick source: 0 is CPU cycles, 1 is A12 line events, 2 is PPU reads and 3 is CPU writes. Ticks from the other sources have no effect.
- R6: Mode bits 7:6 = 01 select counting up. Each tick adds one to the prescaler. When the masked prescaler becomes zero, the counter adds one. A counter result of 0x00 with the enable set raises the interrupt.
- R7: Mode bits 7:6 = 10 select counting down. Each tick subtracts one from the prescaler. When the masked prescaler becomes equal to the mask, the counter subtracts one. A counter result of 0xFF with the enable set raises the interrupt.
- R8: Mode bit 2 set selects a 3-bit prescaler mask (0x07). Mode bit 2 clear selects an 8-bit mask (0xFF).
- R9: Mode bits 7:6 = 00 or 11 stop the block: ticks change neither the prescaler nor the counter.
- R10: An A12 event seen while no burst is running produces one tick on each of the next eight clock edges. Events that arrive during a burst are ignored.
- R11: The interrupt stays high until it is acknowledged. A terminal hit while the enable is clear does not raise it, and setting the enable later does not raise it either.
- R12: If a tick arrives in the same cycle as a write to offset 4 or 5, the load wins and the tick is discarded. If an acknowledge arrives in the same cycle as a terminal hit, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| tick_cpu_cycle | input | 1 | CPU cycle tick |
| tick_a12_line | input | 1 | Qualified A12 line event |
| tick_ppu_read | input | 1 | PPU read strobe tick |
| tick_cpu_write | input | 1 | CPU write strobe tick |
| irq | output | 1 | Level interrupt request |

## Verification
The prescaler and the counter are not visible at the ports. A wrong value in either one therefore shows up only as an interrupt edge that comes too early or too late. With the 3-bit mask, an error in the counter shows up within eight ticks times the counter distance to its terminal value. A wrong prescaler shows up within eight ticks. A wrong burst length moves the interrupt edge by exactly one cycle for every extra or missing tick. The bench therefore loads each case so that the terminal value lies one tick or one burst away, and compares the interrupt line against a reference model on every clock.

// File: rtl/irq_tick_pkg.sv
package irq_tick_pkg;

    typedef enum logic [1:0] {
        SRC_CPU_CYC  = 2'd0,
        SRC_A12_LINE = 2'd1,
        SRC_PPU_RD   = 2'd2,
        SRC_CPU_WR   = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        DIR_HALT_LO = 2'd0,
        DIR_UP      = 2'd1,
        DIR_DOWN    = 2'd2,
        DIR_HALT_HI = 2'd3
    } count_dir_e;

    typedef enum logic {
        BURST_IDLE,
        BURST_RUN
    } burst_state_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

    localparam int OFS_ENABLE  = 0;
    localparam int OFS_MODE    = 1;
    localparam int OFS_DISARM  = 2;
    localparam int OFS_ARM     = 3;
    localparam int OFS_PRELOAD = 4;
    localparam int OFS_CNTLOAD = 5;
    localparam int OFS_KEY     = 6;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_tick_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              enable,
    output logic [DATA_W-1:0] mode,
    output logic              load_pre,
    output logic              load_cnt,
    output logic [DATA_W-1:0] load_val,
    output logic              ack
);

    logic [DATA_W-1:0] key_q;

    always_comb begin
        load_pre = wr_en && (wr_addr == ADDR_W'(OFS_PRELOAD));
        load_cnt = wr_en && (wr_addr == ADDR_W'(OFS_CNTLOAD));
        load_val = wr_data ^ key_q;
        ack      = wr_en && (((wr_addr == ADDR_W'(OFS_ENABLE)) && !wr_data[0])
                          || (wr_addr == ADDR_W'(OFS_DISARM)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            mode   <= '0;
            key_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_W'(OFS_ENABLE): enable <= wr_data[0];
                ADDR_W'(OFS_MODE):   mode   <= wr_data;
                ADDR_W'(OFS_DISARM): enable <= 1'b0;
                ADDR_W'(OFS_ARM):    enable <= 1'b1;
                ADDR_W'(OFS_KEY):    key_q  <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_a12_burst.sv
module irq_a12_burst
    import irq_tick_pkg::*;
#(
    parameter int BURST_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    output logic tick_o
);

    localparam int LEFT_W = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;

    burst_state_e state_q, state_d;
    logic [LEFT_W-1:0] left_q, left_d;

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            BURST_IDLE: begin
                if (event_i) begin
                    state_d = BURST_RUN;
                    left_d  = LEFT_W'(BURST_LEN - 1);
                end
            end
            BURST_RUN: begin
                if (left_q == '0) state_d = BURST_IDLE;
                else              left_d  = left_q - LEFT_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BURST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        tick_o = (state_q == BURST_RUN);
    end

    // R10
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_o) |-> $past(event_i));

endmodule

// File: rtl/irq_count_core.sv
module irq_count_core
    import irq_tick_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tick_src_e         src,
    input  count_dir_e        dir,
    input  logic              fine_sel,
    input  logic              tick_cpu,
    input  logic              tick_a12,
    input  logic              tick_rd,
    input  logic              tick_wr,
    input  logic              load_pre,
    input  logic              load_cnt,
    input  logic [DATA_W-1:0] load_val,
    output logic              terminal_hit
);

    localparam logic [DATA_W-1:0] FINE_MASK = DATA_W'((1 << FINE_W) - 1);

    logic [DATA_W-1:0] pre_q, cnt_q, pre_nx, cnt_nx, mask;
    logic tick_sel, counting, active, step;

    always_comb begin
        unique case (src)
            SRC_CPU_CYC:  tick_sel = tick_cpu;
            SRC_A12_LINE: tick_sel = tick_a12;
            SRC_PPU_RD:   tick_sel = tick_rd;
            SRC_CPU_WR:   tick_sel = tick_wr;
        endcase
        mask     = fine_sel ? FINE_MASK : '1;
        counting = (dir == DIR_UP) || (dir == DIR_DOWN);
        active   = tick_sel && counting && !load_pre && !load_cnt;
        if (dir == DIR_UP) begin
            pre_nx = pre_q + DATA_W'(1);
            cnt_nx = cnt_q + DATA_W'(1);
            step   = (pre_nx & mask) == '0;
            terminal_hit = active && step && (cnt_nx == '0);
        end else begin
            pre_nx = pre_q - DATA_W'(1);
            cnt_nx = cnt_q - DATA_W'(1);
            step   = (pre_nx & mask) == mask;
            terminal_hit = active && step && (cnt_nx == '1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (load_pre) pre_q <= load_val;
            if (load_cnt) cnt_q <= load_val;
            if (active) begin
                pre_q <= pre_nx;
                if (step) cnt_q <= cnt_nx;
            end
        end
    end

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !load_pre && !load_cnt) |=> ($stable(cnt_q) && $stable(pre_q)));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + DATA_W'(1)
                       || cnt_q == $past(cnt_q) - DATA_W'(1)));

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
    import irq_tick_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int FINE_W    = 3,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick_cpu_cycle,
    input  logic              tick_a12_line,
    input  logic              tick_ppu_read,
    input  logic              tick_cpu_write,
    output logic              irq
);

    logic              enable, load_pre, load_cnt, ack, hit, a12_tick;
    logic [DATA_W-1:0] mode, load_val;
    irq_state_e        state_q, state_d;

    irq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .enable(enable), .mode(mode),
        .load_pre(load_pre), .load_cnt(load_cnt), .load_val(load_val), .ack(ack)
    );

    irq_a12_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk(clk), .rst_n(rst_n), .event_i(tick_a12_line), .tick_o(a12_tick)
    );

    irq_count_core #(.DATA_W(DATA_W), .FINE_W(FINE_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .src(tick_src_e'(mode[1:0])),
        .dir(count_dir_e'(mode[DATA_W-1:DATA_W-2])),
        .fine_sel(mode[2]),
        .tick_cpu(tick_cpu_cycle), .tick_a12(a12_tick),
        .tick_rd(tick_ppu_read), .tick_wr(tick_cpu_write),
        .load_pre(load_pre), .load_cnt(load_cnt), .load_val(load_val),
        .terminal_hit(hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (hit && enable && !ack) state_d = IRQ_RAISED;
            IRQ_RAISED: if (ack)                   state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    // R2
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enable));

endmodule

// File: tb/irq_line_counter_test.sv
module irq_line_counter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick_cpu_cycle = 1'b0, tick_a12_line = 1'b0;
    logic       tick_ppu_read = 1'b0, tick_cpu_write = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_en, m_mode, m_key, m_pre, m_cnt, m_left, m_irq;

    always #5 clk = ~clk;

    irq_line_counter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_cpu_cycle(tick_cpu_cycle), .tick_a12_line(tick_a12_line),
        .tick_ppu_read(tick_ppu_read), .tick_cpu_write(tick_cpu_write), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_mode = 0; m_key = 0; m_pre = 0; m_cnt = 0; m_left = 0; m_irq = 0;
        end else begin
            int src, dir, mask, t, ld, ack, hit, bt, p, c, d;
            bt = (m_left > 0);
            if (m_left > 0) m_left--;
            else if (tick_a12_line) m_left = 8;
            src  = m_mode & 3;
            dir  = (m_mode >> 6) & 3;
            mask = ((m_mode >> 2) & 1) ? 7 : 255;
            t = (src == 0) ? tick_cpu_cycle : (src == 1) ? bt :
                (src == 2) ? tick_ppu_read : tick_cpu_write;
            d   = wr_data;
            ld  = wr_en && (wr_addr == 4 || wr_addr == 5);
            ack = wr_en && ((wr_addr == 0 && (d & 1) == 0) || wr_addr == 2);
            hit = 0;
            if (t && !ld && (dir == 1 || dir == 2)) begin
                p = (dir == 1) ? ((m_pre + 1) & 255) : ((m_pre + 255) & 255);
                m_pre = p;
                if (dir == 1 && (p & mask) == 0) begin
                    c = (m_cnt + 1) & 255; m_cnt = c; hit = (c == 0);
                end else if (dir == 2 && (p & mask) == mask) begin
                    c = (m_cnt + 255) & 255; m_cnt = c; hit = (c == 255);
                end
            end
            if (ack) m_irq = 0;
            else if (hit && m_en) m_irq = 1;
            if (wr_en) begin
                case (wr_addr)
                    0: m_en = d & 1;
                    1: m_mode = d;
                    2: m_en = 0;
                    3: m_en = 1;
                    4: m_pre = d ^ m_key;
                    5: m_cnt = d ^ m_key;
                    6: m_key = d;
                    default: ;
                endcase
            end
        end
    end

    // every-clock comparison against the model (R11 level behaviour)
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (irq !== m_irq[0]) begin
                n_fail++;
                $display("FAIL R11 per-cycle compare at %0t: irq=%b expected %b", $time, irq, m_irq[0]);
            end
        end
    end

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected %b", tag, irq, exp);
        end
    endtask

    task automatic cyc(input bit w, input int a, input int d, input bit [3:0] tk);
        wr_en = w; wr_addr = a[2:0]; wr_data = d[7:0];
        {tick_cpu_write, tick_ppu_read, tick_a12_line, tick_cpu_cycle} = tk;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        {tick_cpu_write, tick_ppu_read, tick_a12_line, tick_cpu_cycle} = '0;
    endtask

    task automatic wr(input int a, input int d);
        cyc(1'b1, a, d, 4'b0000);
    endtask

    task automatic tk(input bit [3:0] m);
        cyc(1'b0, 0, 0, m);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 4'b0000);
    endtask

    task automatic rearm();
        wr(2, 0);
        wr(3, 0);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq low after reset", 1'b0);

        // R1/R6/R8: zeroed prescaler and counter need 256*8 ticks to wrap
        wr(3, 0);
        wr(1, 'h44);
        for (int i = 0; i < 2047; i++) tk(4'b0001);
        chk("R1 zero state, no irq one tick early", 1'b0);
        tk(4'b0001);
        chk("R6 up count reaches 0x00", 1'b1);
        idle(5);
        chk("R11 irq held", 1'b1);
        wr(0, 0);
        chk("R2 enable write of 0 acknowledges", 1'b0);
        wr(0, 1);

        // R4 keyed loads
        wr(6, 'h5A);
        wr(5, 'hFF ^ 'h5A);
        wr(4, 'h07 ^ 'h5A);
        chk("R4 no irq before tick", 1'b0);
        tk(4'b0001);
        chk("R4 keyed load one tick from terminal", 1'b1);
        wr(2, 0);
        chk("R3 disarm clears irq", 1'b0);

        // R11 hit while disabled
        wr(6, 0);
        wr(5, 'hFF);
        wr(4, 'h07);
        tk(4'b0001);
        chk("R11 no irq while disabled", 1'b0);
        wr(3, 0);
        chk("R3 arm does not raise irq", 1'b0);

        // R7 down count
        wr(1, 'h84);
        wr(5, 0);
        wr(4, 0);
        tk(4'b0001);
        chk("R7 down count reaches 0xFF", 1'b1);
        rearm();

        // R5 source select: PPU reads
        wr(1, 'h46);
        wr(5, 'hFF);
        wr(4, 'h07);
        tk(4'b1011);
        idle(10);
        chk("R5 other sources ignored (read src)", 1'b0);
        tk(4'b0100);
        chk("R5 ppu read tick counts", 1'b1);
        rearm();

        // R5 source select: CPU writes
        wr(1, 'h47);
        wr(5, 'hFF);
        wr(4, 'h07);
        tk(4'b0111);
        idle(10);
        chk("R5 other sources ignored (write src)", 1'b0);
        tk(4'b1000);
        chk("R5 cpu write tick counts", 1'b1);
        rearm();

        // R10 A12 burst of eight ticks
        wr(1, 'h45);
        wr(5, 'hFF);
        wr(4, 0);
        tk(4'b0010);
        idle(7);
        chk("R10 seven burst ticks not enough", 1'b0);
        idle(1);
        chk("R10 eighth burst tick hits", 1'b1);
        rearm();

        // R10 events during a burst ignored
        wr(5, 'hFE);
        wr(4, 0);
        tk(4'b0010);
        idle(2);
        tk(4'b0010);
        idle(12);
        chk("R10 event inside burst ignored", 1'b0);
        tk(4'b0010);
        idle(8);
        chk("R10 next burst completes count", 1'b1);
        rearm();

        // R9 stopped modes
        wr(1, 'h04);
        wr(5, 'hFF);
        wr(4, 'h07);
        for (int i = 0; i < 20; i++) tk(4'b0001);
        chk("R9 stopped 00 no count", 1'b0);
        wr(1, 'hC4);
        for (int i = 0; i < 20; i++) tk(4'b0001);
        chk("R9 stopped 11 no count", 1'b0);
        wr(1, 'h44);
        tk(4'b0001);
        chk("R9 state untouched while stopped", 1'b1);
        rearm();

        // R8 8-bit mask
        wr(1, 'h40);
        wr(5, 'hFF);
        wr(4, 'h07);
        tk(4'b0001);
        chk("R8 8-bit mask no wrap at 0x08", 1'b0);
        wr(4, 'hFE);
        tk(4'b0001);
        chk("R8 8-bit mask no wrap at 0xFF", 1'b0);
        tk(4'b0001);
        chk("R8 8-bit mask wraps at 0x00", 1'b1);
        rearm();

        // R12 priorities
        wr(1, 'h44);
        wr(5, 'hFF);
        wr(4, 'h07);
        cyc(1'b1, 4, 'h07, 4'b0001);
        chk("R12 load discards same-cycle tick", 1'b0);
        tk(4'b0001);
        chk("R12 following tick hits", 1'b1);
        rearm();
        wr(5, 'hFF);
        wr(4, 'h07);
        cyc(1'b1, 2, 0, 4'b0001);
        chk("R12 acknowledge beats same-cycle hit", 1'b0);

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule